// File: doc/BRIEF.md
# Proof-of-Work Nonce Search Controller

This block runs a nonce search through one external hash core. A job has three parts: a 640-bit block header, a 256-bit target and a 32-bit nonce limit. When a job is loaded, the controller takes the starting nonce from header word 19. It then writes the current nonce into that word and issues a one-cycle start to the hash core. It waits for the core's done pulse, for as many cycles as the core needs. When done arrives, it captures the 256-bit result and compares it against the target.

If the result is strictly below the target, the controller emits a one-cycle `found` pulse. In the same cycle it presents the winning nonce and its hash. If the compare fails and the nonce limit has been reached, it emits a one-cycle `exhausted` pulse. Otherwise it increments the nonce and launches the core again. A job load that arrives while a search is running abandons that search. If a hash is still in flight, the controller absorbs its done pulse without acting on it, and only then launches the new job.

The sequencer has five states:
- `S_IDLE`: no search is running.
- `S_LAUNCH`: start pulse to the core.
- `S_WAIT`: hash in flight.
- `S_JUDGE`: compare the captured hash.
- `S_DRAIN`: an abandoned hash is still in flight.

Its transitions are:
- IDLE→LAUNCH on load.
- LAUNCH→WAIT, or LAUNCH→DRAIN on load.
- WAIT→JUDGE on done. WAIT→DRAIN on load without done. WAIT→LAUNCH on load together with done.
- JUDGE→IDLE on hit or limit. JUDGE→LAUNCH on miss below the limit, or on load.
- DRAIN→LAUNCH on done.

Top module: `nonce_search_ctrl`

## Requirements
- R1: After reset, `busy`, `found`, `exhausted` and `hc_start` are all low.
- R2: In the cycle after `job_load` is sampled, `busy` is high and `hc_start` pulses for exactly one cycle. `hc_header` then carries header words 0..18 (word i at bits [32i+31:32i]) unchanged, and word 19 (bits [639:608]) holds the nonce, which starts at the loaded header's word 19.
- R3: A hash wins only if it is strictly less than the target. Both are compared as unsigned 256-bit values, with word 7 (bits [255:224]) most significant and word 0 least. A hash equal to the target loses, and a larger top word rejects the hash at once.
- R4: After a losing hash below the limit, the next launch uses the previous nonce plus one, with words 0..18 unchanged.
- R5: After a losing hash whose nonce is greater than or equal to the limit, `exhausted` pulses for one cycle. `busy` is low in that cycle, and no further launch follows. The nonce never wraps past 32'hFFFFFFFF.
- R6: On a win, `found` pulses for one cycle with `busy` low. `gold_nonce` and `gold_hash` show the winning nonce and hash in that cycle, and no further launch follows.
- R7: The controller waits any number of cycles for `hc_done` between launches.
- R8: A `job_load` while busy abandons the current search. A done pulse from a hash already in flight causes no result and no launch of the old job. The new job's first launch comes only after that done pulse.
- R9: `found` and `exhausted` are never high together. A new launch is never issued while a hash is in flight, and never while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_load | input | 1 | Load job fields; restarts if busy |
| job_header | input | 640 | Block header, word 19 = starting nonce |
| job_target | input | 256 | Target the hash must be below |
| job_max_nonce | input | 32 | Last nonce to try |
| hc_start | output | 1 | One-cycle start to the hash core |
| hc_header | output | 640 | Header with current nonce spliced in |
| hc_done | input | 1 | Hash core done pulse |
| hc_hash | input | 256 | Hash core result, valid with done |
| busy | output | 1 | Search in progress |
| found | output | 1 | One-cycle winning-nonce pulse |
| exhausted | output | 1 | One-cycle limit-reached pulse |
| gold_nonce | output | 32 | Winning nonce, valid with found |
| gold_hash | output | 256 | Winning hash, valid with found |

## Verification
The hardest case to reach is a restart that lands while a hash is in flight, where that abandoned hash would have won. Only a correct drain keeps that stale done from producing a result. The bench stretches the stand-in core's latency to 30 cycles. It issues the new job right after it sees the old job's second launch, and it makes that second nonce produce a winning hash. The only acceptable outcome is then one result, carrying the new job's nonce, whose launch follows the stale done. Separate single-nonce jobs isolate the compare's word ordering, the equality case and the top-word reject.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LAUNCH,
        S_WAIT,
        S_JUDGE,
        S_DRAIN
    } seq_state_t;
endpackage

// File: rtl/nsc_job_regs.sv
module nsc_job_regs #(
    parameter int WORD_W     = 32,
    parameter int HDR_WORDS  = 20,
    parameter int HASH_WORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic                          advance,
    input  logic [HDR_WORDS*WORD_W-1:0]   job_header,
    input  logic [HASH_WORDS*WORD_W-1:0]  job_target,
    input  logic [WORD_W-1:0]             job_max,
    output logic [HDR_WORDS*WORD_W-1:0]   hc_header,
    output logic [HASH_WORDS*WORD_W-1:0]  target_q,
    output logic [WORD_W-1:0]             nonce_q,
    output logic                          at_limit
);
    localparam int NONCE_IDX = HDR_WORDS - 1;
    localparam int FIXED_W   = NONCE_IDX * WORD_W;

    logic [FIXED_W-1:0] fixed_q;
    logic [WORD_W-1:0]  max_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fixed_q  <= '0;
            target_q <= '0;
            max_q    <= '0;
            nonce_q  <= '0;
        end else if (load) begin
            fixed_q  <= job_header[FIXED_W-1:0];
            target_q <= job_target;
            max_q    <= job_max;
            nonce_q  <= job_header[NONCE_IDX*WORD_W +: WORD_W];
        end else if (advance) begin
            nonce_q  <= nonce_q + 1'b1;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < HDR_WORDS; gi++) begin : g_word
            if (gi == NONCE_IDX) begin : g_nonce
                assign hc_header[gi*WORD_W +: WORD_W] = nonce_q;
            end else begin : g_fixed
                assign hc_header[gi*WORD_W +: WORD_W] = fixed_q[gi*WORD_W +: WORD_W];
            end
        end
    endgenerate

    assign at_limit = (nonce_q >= max_q);

    // R2: the nonce seeded by a load is the header's last word
    p_load_nonce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (nonce_q == $past(job_header[NONCE_IDX*WORD_W +: WORD_W])));
endmodule

// File: rtl/nsc_mag_cmp.sv
module nsc_mag_cmp #(
    parameter int WORD_W     = 32,
    parameter int HASH_WORDS = 8
) (
    input  logic [HASH_WORDS*WORD_W-1:0] hash,
    input  logic [HASH_WORDS*WORD_W-1:0] target,
    output logic                         top_reject,
    output logic                         hash_below
);
    localparam int TOP = HASH_WORDS - 1;

    logic [HASH_WORDS-1:0] w_lt;
    logic [HASH_WORDS-1:0] w_eq;

    genvar gi;
    generate
        for (gi = 0; gi < HASH_WORDS; gi++) begin : g_cmp
            assign w_lt[gi] = hash[gi*WORD_W +: WORD_W] <  target[gi*WORD_W +: WORD_W];
            assign w_eq[gi] = hash[gi*WORD_W +: WORD_W] == target[gi*WORD_W +: WORD_W];
        end
    endgenerate

    assign top_reject = !w_lt[TOP] && !w_eq[TOP];

    always_comb begin
        logic decided;
        decided    = 1'b0;
        hash_below = 1'b0;
        for (int i = TOP; i >= 0; i--) begin
            if (!decided) begin
                if (w_lt[i]) begin
                    hash_below = 1'b1;
                    decided    = 1'b1;
                end else if (!w_eq[i]) begin
                    decided    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/nsc_seq.sv
module nsc_seq
    import nsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic job_load,
    input  logic hc_done,
    input  logic hit,
    input  logic at_limit,
    output logic hc_start,
    output logic busy,
    output logic capture,
    output logic advance,
    output logic found_set,
    output logic exh_set
);
    seq_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (job_load) state_nx = S_LAUNCH;
            S_LAUNCH: state_nx = job_load ? S_DRAIN : S_WAIT;
            S_WAIT: begin
                if (job_load)     state_nx = hc_done ? S_LAUNCH : S_DRAIN;
                else if (hc_done) state_nx = S_JUDGE;
            end
            S_JUDGE: begin
                if (job_load)             state_nx = S_LAUNCH;
                else if (hit || at_limit) state_nx = S_IDLE;
                else                      state_nx = S_LAUNCH;
            end
            S_DRAIN:  if (hc_done) state_nx = S_LAUNCH;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        hc_start  = (state == S_LAUNCH);
        busy      = (state != S_IDLE);
        capture   = (state == S_WAIT) && hc_done && !job_load;
        advance   = 1'b0;
        found_set = 1'b0;
        exh_set   = 1'b0;
        if (state == S_JUDGE && !job_load) begin
            found_set = hit;
            exh_set   = !hit && at_limit;
            advance   = !hit && !at_limit;
        end
    end

    // R2: start lasts exactly one cycle
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hc_start |=> !hc_start);
    // R2: a load always leaves the block busy
    p_load_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        job_load |=> busy);
    // R8: draining holds until the abandoned hash reports
    p_drain_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DRAIN && !hc_done) |=> (state == S_DRAIN && !hc_start));
endmodule

// File: rtl/nonce_search_ctrl.sv
module nonce_search_ctrl #(
    parameter int WORD_W     = 32,
    parameter int HDR_WORDS  = 20,
    parameter int HASH_WORDS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         job_load,
    input  logic [HDR_WORDS*WORD_W-1:0]  job_header,
    input  logic [HASH_WORDS*WORD_W-1:0] job_target,
    input  logic [WORD_W-1:0]            job_max_nonce,
    output logic                         hc_start,
    output logic [HDR_WORDS*WORD_W-1:0]  hc_header,
    input  logic                         hc_done,
    input  logic [HASH_WORDS*WORD_W-1:0] hc_hash,
    output logic                         busy,
    output logic                         found,
    output logic                         exhausted,
    output logic [WORD_W-1:0]            gold_nonce,
    output logic [HASH_WORDS*WORD_W-1:0] gold_hash
);
    localparam int HASH_W = HASH_WORDS * WORD_W;

    logic              capture, advance, found_set, exh_set;
    logic              at_limit, top_reject, hash_below, hit;
    logic [HASH_W-1:0] hash_q, target_q;
    logic [WORD_W-1:0] nonce_q;

    nsc_job_regs #(.WORD_W(WORD_W), .HDR_WORDS(HDR_WORDS), .HASH_WORDS(HASH_WORDS)) u_job (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (job_load),
        .advance    (advance),
        .job_header (job_header),
        .job_target (job_target),
        .job_max    (job_max_nonce),
        .hc_header  (hc_header),
        .target_q   (target_q),
        .nonce_q    (nonce_q),
        .at_limit   (at_limit)
    );

    nsc_mag_cmp #(.WORD_W(WORD_W), .HASH_WORDS(HASH_WORDS)) u_cmp (
        .hash       (hash_q),
        .target     (target_q),
        .top_reject (top_reject),
        .hash_below (hash_below)
    );

    assign hit = !top_reject && hash_below;

    nsc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .job_load  (job_load),
        .hc_done   (hc_done),
        .hit       (hit),
        .at_limit  (at_limit),
        .hc_start  (hc_start),
        .busy      (busy),
        .capture   (capture),
        .advance   (advance),
        .found_set (found_set),
        .exh_set   (exh_set)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       hash_q <= '0;
        else if (capture) hash_q <= hc_hash;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            found      <= 1'b0;
            exhausted  <= 1'b0;
            gold_nonce <= '0;
            gold_hash  <= '0;
        end else begin
            found     <= found_set;
            exhausted <= exh_set;
            if (found_set) begin
                gold_nonce <= nonce_q;
                gold_hash  <= hash_q;
            end
        end
    end

    // R3: a hit always means strictly below the target
    p_hit_strict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        found_set |-> (hash_q < target_q));
    // R4: a miss steps the nonce by one
    p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (nonce_q == $past(nonce_q) + 1'b1));
    // R5: exhaustion ends the search
    p_exh_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exhausted |-> (!busy && !hc_start));
    // R6: a win ends the search
    p_found_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (!busy && !hc_start));
    // R9: the two end pulses are exclusive
    p_end_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(found && exhausted));
endmodule

// File: tb/tb_nonce_search_ctrl.sv
module tb_nonce_search_ctrl;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         job_load = 1'b0;
    logic [639:0] job_header = '0;
    logic [255:0] job_target = '0;
    logic [31:0]  job_max_nonce = '0;
    logic         hc_start;
    logic [639:0] hc_header;
    logic         hc_done = 1'b0;
    logic [255:0] hc_hash = '0;
    logic         busy, found, exhausted;
    logic [31:0]  gold_nonce;
    logic [255:0] gold_hash;

    nonce_search_ctrl dut (
        .clk(clk), .rst_n(rst_n), .job_load(job_load), .job_header(job_header),
        .job_target(job_target), .job_max_nonce(job_max_nonce),
        .hc_start(hc_start), .hc_header(hc_header), .hc_done(hc_done), .hc_hash(hc_hash),
        .busy(busy), .found(found), .exhausted(exhausted),
        .gold_nonce(gold_nonce), .gold_hash(gold_hash)
    );

    int checks = 0;
    int fails  = 0;

    // stand-in hash core state
    int           core_lat = 2;
    int           cnt = 0;
    logic [31:0]  pend = '0;
    logic [31:0]  win_a = '0, win_b = '0;
    logic [255:0] hash_a = '0, hash_b = '0;
    logic [255:0] hash_lose = '1;

    // monitor state
    int           start_cnt = 0, found_cnt = 0, exh_cnt = 0;
    int           overlap_err = 0, idle_start_err = 0, found_busy_err = 0, exh_busy_err = 0;
    logic [31:0]  nonce_log [0:15];
    logic [639:0] last_hdr = '0;
    logic [31:0]  g_nonce = '0;
    logic [255:0] g_hash = '0;

    function automatic logic [255:0] hash_of(input logic [31:0] n);
        if (n == win_a)      return hash_a;
        else if (n == win_b) return hash_b;
        else                 return hash_lose;
    endfunction

    function automatic logic [639:0] mk_header(input logic [31:0] seed, input logic [31:0] n);
        logic [639:0] h;
        for (int i = 0; i < 19; i++) h[i*32 +: 32] = seed + i;
        h[639:608] = n;
        return h;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            hc_done = 1'b0;
            if (cnt > 0) begin
                cnt = cnt - 1;
                if (cnt == 0) begin
                    hc_done = 1'b1;
                    hc_hash = hash_of(pend);
                end
            end
            if (hc_start) begin
                if (cnt > 0) overlap_err++;
                if (!busy)   idle_start_err++;
                pend = hc_header[639:608];
                cnt  = core_lat;
                nonce_log[start_cnt % 16] = pend;
                last_hdr = hc_header;
                start_cnt++;
            end
            if (found) begin
                found_cnt++;
                g_nonce = gold_nonce;
                g_hash  = gold_hash;
                if (busy) found_busy_err++;
            end
            if (exhausted) begin
                exh_cnt++;
                if (busy) exh_busy_err++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply_job(input logic [639:0] h, input logic [255:0] t, input logic [31:0] mx);
        @(negedge clk);
        job_header    = h;
        job_target    = t;
        job_max_nonce = mx;
        job_load      = 1'b1;
        @(negedge clk);
        job_load      = 1'b0;
    endtask

    task automatic wait_end(input int base, input int limit);
        int n = 0;
        while ((found_cnt + exh_cnt) == base && n < limit) begin
            @(posedge clk);
            n++;
        end
        chk((found_cnt + exh_cnt) != base, "R7", "search ended before timeout", n, limit);
        repeat (3) @(posedge clk);
    endtask

    task automatic quiet_after(input string req);
        int s0 = start_cnt;
        repeat (10) @(posedge clk);
        chk(start_cnt == s0, req, "no launch after end", start_cnt, s0);
        chk(!busy, req, "idle after end", busy, 0);
    endtask

    task automatic t_basic;
        logic [639:0] h = mk_header(32'h1000, 32'd100);
        logic [255:0] t = {32'h1, 224'h0};
        int s0 = start_cnt, f0 = found_cnt, e0 = exh_cnt;
        core_lat = 2; win_a = 32'd103; hash_a = t - 1; win_b = 32'hDEAD0000;
        apply_job(h, t, 32'd200);
        chk(busy, "R2", "busy after load", busy, 1);
        wait_end(f0 + e0, 500);
        chk(start_cnt - s0 == 4, "R4", "launch count", start_cnt - s0, 4);
        for (int i = 0; i < 4; i++)
            chk(nonce_log[(s0 + i) % 16] == 32'd100 + i, "R4", "nonce sequence",
                nonce_log[(s0 + i) % 16], 32'd100 + i);
        chk(nonce_log[s0 % 16] == 32'd100, "R2", "first nonce from header", nonce_log[s0 % 16], 100);
        chk(last_hdr[607:0] == h[607:0], "R2", "fixed words kept", last_hdr[255:0], h[255:0]);
        chk(found_cnt - f0 == 1, "R6", "single found pulse", found_cnt - f0, 1);
        chk(exh_cnt == e0, "R6", "no exhausted on win", exh_cnt - e0, 0);
        chk(g_nonce == 32'd103, "R6", "gold nonce", g_nonce, 103);
        chk(g_hash == hash_a, "R6", "gold hash", g_hash, hash_a);
        quiet_after("R6");
    endtask

    task automatic t_equal;
        logic [255:0] t = {32'h2, 224'h5};
        int s0 = start_cnt, f0 = found_cnt, e0 = exh_cnt;
        win_a = 32'd6; hash_a = t; win_b = 32'hDEAD0000;
        apply_job(mk_header(32'h2000, 32'd5), t, 32'd7);
        wait_end(f0 + e0, 500);
        chk(found_cnt == f0, "R3", "equal hash rejected", found_cnt - f0, 0);
        chk(exh_cnt - e0 == 1, "R5", "exhausted once", exh_cnt - e0, 1);
        chk(start_cnt - s0 == 3, "R5", "tries up to limit inclusive", start_cnt - s0, 3);
        quiet_after("R5");
    endtask

    task automatic run_single(input logic [255:0] t, input logic [255:0] hv,
                              input bit exp_win, input string what);
        int f0 = found_cnt, e0 = exh_cnt;
        win_a = 32'd1; hash_a = hv; win_b = 32'hDEAD0000;
        apply_job(mk_header(32'h3000, 32'd1), t, 32'd1);
        wait_end(f0 + e0, 500);
        chk((found_cnt - f0) == int'(exp_win), "R3", what, found_cnt - f0, exp_win);
    endtask

    task automatic t_order;
        run_single({32'h10, 224'h0}, {32'h0F, {224{1'b1}}}, 1'b1, "top word decides low");
        run_single({32'h5, 192'h0, 32'h9}, {32'h5, 192'h0, 32'h8}, 1'b1, "word 0 decides low");
        run_single({32'h5, 192'h0, 32'h9}, {32'h5, 192'h0, 32'h9}, 1'b0, "word 0 equal rejects");
        run_single({32'h10, {224{1'b1}}}, {32'h11, 224'h0}, 1'b0, "top word fast reject");
    endtask

    task automatic t_start_above;
        int s0 = start_cnt, f0 = found_cnt, e0 = exh_cnt;
        win_a = 32'hDEAD0001; win_b = 32'hDEAD0000;
        apply_job(mk_header(32'h4000, 32'd50), {32'h1, 224'h0}, 32'd10);
        wait_end(f0 + e0, 500);
        chk(start_cnt - s0 == 1, "R5", "start above limit tries once", start_cnt - s0, 1);
        chk(exh_cnt - e0 == 1, "R5", "start above limit exhausts", exh_cnt - e0, 1);
    endtask

    task automatic t_slow;
        int f0 = found_cnt, e0 = exh_cnt;
        core_lat = 40;
        win_a = 32'd2; hash_a = 256'h1; win_b = 32'hDEAD0000;
        apply_job(mk_header(32'h6000, 32'd0), {32'h1, 224'h0}, 32'd3);
        wait_end(f0 + e0, 1000);
        chk(found_cnt - f0 == 1 && g_nonce == 32'd2, "R7", "slow core found nonce", g_nonce, 2);
        core_lat = 2;
    endtask

    task automatic t_restart;
        logic [639:0] hb = mk_header(32'h5000, 32'h300);
        int s0 = start_cnt, f0 = found_cnt, e0 = exh_cnt;
        int n = 0;
        core_lat = 30;
        win_a = 32'h201; hash_a = 256'h1;
        win_b = 32'h300; hash_b = 256'h2;
        apply_job(mk_header(32'h7000, 32'h200), {32'h1, 224'h0}, 32'h2FF);
        while (start_cnt < s0 + 2 && n < 200) begin @(posedge clk); n++; end
        apply_job(hb, {32'h1, 224'h0}, 32'h300);
        chk(busy, "R8", "busy through drain", busy, 1);
        chk(start_cnt == s0 + 2, "R8", "no launch before stale done", start_cnt - s0, 2);
        wait_end(f0 + e0, 1000);
        chk(found_cnt - f0 == 1, "R8", "one result after restart", found_cnt - f0, 1);
        chk(g_nonce == 32'h300, "R8", "result from new job", g_nonce, 32'h300);
        chk(start_cnt - s0 == 3, "R8", "one launch of new job", start_cnt - s0, 3);
        chk(last_hdr == hb, "R8", "new job header launched", last_hdr[255:0], hb[255:0]);
        core_lat = 2;
    endtask

    task automatic t_wrap;
        int s0 = start_cnt, f0 = found_cnt, e0 = exh_cnt;
        win_a = 32'h12345; win_b = 32'hDEAD0000;
        apply_job(mk_header(32'h8000, 32'hFFFF_FFFE), {32'h1, 224'h0}, 32'hFFFF_FFFF);
        wait_end(f0 + e0, 500);
        chk(start_cnt - s0 == 2, "R5", "no wrap launches", start_cnt - s0, 2);
        chk(nonce_log[(s0 + 1) % 16] == 32'hFFFF_FFFF, "R5", "last nonce", nonce_log[(s0 + 1) % 16], 32'hFFFF_FFFF);
        chk(exh_cnt - e0 == 1, "R5", "exhausted at top", exh_cnt - e0, 1);
        quiet_after("R5");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !found && !exhausted && !hc_start, "R1", "reset outputs low",
            {busy, found, exhausted, hc_start}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !hc_start, "R1", "idle after reset", {busy, hc_start}, 0);
        t_basic();
        t_equal();
        t_order();
        t_start_above();
        t_slow();
        t_restart();
        t_wrap();
        chk(overlap_err == 0, "R9", "no launch while in flight", overlap_err, 0);
        chk(idle_start_err == 0, "R9", "no launch while idle", idle_start_err, 0);
        chk(found_busy_err == 0, "R6", "busy low with found", found_busy_err, 0);
        chk(exh_busy_err == 0, "R5", "busy low with exhausted", exh_busy_err, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule